// File: doc/BRIEF.md
# Receive FIFO with Programmable Fill Trigger

This block is the receive-side byte queue of a serial controller. A deserializer in front of it hands over complete bytes with a one-cycle strobe. The block keeps up to sixteen of them in arrival order in a circular store. The data-register read path removes them one at a time. Bit timing, baud generation and the rest of the register file sit outside the block.

A 2-bit trigger-select field picks how full the queue must be before software is told about it. The four codes map to the non-linear fill levels 1, 4, 8 and 14. When a stored byte brings the fill count up to the level, a data-full flag is set. If the receive-interrupt enable is also on, the interrupt line is raised. Every pop re-checks the flag against the level. A clear strobe empties the queue at once.

Top module: `rx_trig_fifo`

## Requirements
- R1: Bytes are read out in the order they were stored. The read and write positions wrap around after the sixteenth slot, so a fill started at any position keeps its order.
- R2: The trigger level is decoded from `trig_sel` as follows: 2'b00 gives 1, 2'b01 gives 4, 2'b10 gives 8 and 2'b11 gives 14. After reset, with `trig_sel` at 2'b00, the level is 1.
- R3: A byte is stored only when `rx_valid` is high, `rx_en` is high and `fill_count` is below 16. `rx_ready` is high exactly when those last two conditions hold. A byte offered while the count is 16 is dropped, and the count stays at 16.
- R4: On a cycle that stores a byte and pops none, `data_full` becomes 1 if the new count is at or above the trigger level. Otherwise it keeps its value.
- R5: A `rd_pop` with a nonzero count removes the oldest byte, which `rd_data` shows combinationally during that cycle. On a pop-only cycle, `data_full` drops to 0 if the new count is below the trigger level. Otherwise it keeps its value.
- R6: When the count is 0, `rd_data` is 8'h00, and a `rd_pop` changes neither the count nor the flags.
- R7: A cycle that both stores and pops leaves the count unchanged and advances both positions. `data_full` then equals (count >= level).
- R8: `fifo_clear` empties the queue and clears `data_full` on the next edge. It takes priority over a store or a pop in the same cycle.
- R9: A store that brings the count to or above the level while `rx_irq_en` is high raises `rx_irq`. `rx_irq` is low in any cycle in which `rx_irq_en` is low. A pending interrupt is discarded at the first edge with `rx_irq_en` low, so re-enabling alone does not bring it back.
- R10: After reset the count is 0, and `data_full` and `rx_irq` are 0.
- R11: While `rx_en` is low, offered bytes are ignored and `rx_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | One-cycle strobe: a received byte is on `rx_data` |
| rx_data | input | 8 | Received byte |
| rd_pop | input | 1 | Receive data register read strobe |
| fifo_clear | input | 1 | Empties the queue |
| trig_sel | input | 2 | Trigger level select |
| rx_en | input | 1 | Receive enable control bit |
| rx_irq_en | input | 1 | Receive interrupt enable control bit |
| rd_data | output | 8 | Oldest stored byte, 8'h00 when empty |
| fill_count | output | 5 | Number of stored bytes, 0 to 16 |
| rx_ready | output | 1 | A byte offered now would be stored |
| data_full | output | 1 | Fill level reached flag |
| rx_irq | output | 1 | Receive interrupt |

## Verification
Some properties are checked on every cycle: the count never exceeds sixteen, a full or disabled queue never signals readiness, an empty queue reads as zero, a paired store and pop leaves the count unchanged, and a clear always empties the queue. The same per-cycle checks cover the one-directional flag rules and the masking of the interrupt by its enable. Other behaviour needs the directed scenarios. These include byte order across a pointer wrap, the exact fill count at which each of the four trigger codes sets the flag, the dropped seventeenth byte, and an interrupt that was masked while pending and must not come back when re-enabled.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

  // Fill level selected by the 2-bit trigger field (non-linear map).
  function automatic int unsigned trig_level(input logic [1:0] sel);
    case (sel)
      2'b00:   return 1;
      2'b01:   return 4;
      2'b10:   return 8;
      default: return 14;
    endcase
  endfunction

  // Next value of the data-full flag given this cycle's queue events.
  // at_level: the post-update count is at or above the trigger level.
  function automatic logic flag_update(input logic cur, input logic push,
                                       input logic pop, input logic at_level);
    case ({push, pop})
      2'b10:   return cur | at_level;
      2'b01:   return cur & at_level;
      2'b11:   return at_level;
      default: return cur;
    endcase
  endfunction

endpackage

// File: rtl/rxf_store.sv
module rxf_store #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned W     = 8,
  localparam int unsigned PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr,
  input  logic [W-1:0] wr_data,
  input  logic         rd,
  input  logic         clr,
  input  logic         empty,
  output logic [W-1:0] rd_data
);

  localparam bit POW2 = ((DEPTH & (DEPTH - 1)) == 0);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] head_q, tail_q;
  logic [PW-1:0] head_inc, tail_inc;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    if (POW2) return p + PW'(1);
    else      return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  assign head_inc = bump(head_q);
  assign tail_inc = bump(tail_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
    end else if (clr) begin
      head_q <= '0;
      tail_q <= '0;
    end else begin
      if (wr) head_q <= head_inc;
      if (rd) tail_q <= tail_inc;
    end
  end

  always_ff @(posedge clk) begin
    if (wr && !clr) mem[head_q] <= wr_data;
  end

  assign rd_data = empty ? '0 : mem[tail_q];

  // A read must never move the tail while the queue is empty.
  AST_NO_EMPTY_POP: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && !clr && !wr) |=> $stable(tail_q)); // R6

endmodule

// File: rtl/rxf_level.sv
module rxf_level #(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_fire,
  input  logic          pop_fire,
  input  logic          clr,
  input  logic [CW-1:0] lvl,
  output logic [CW-1:0] cnt_q,
  output logic          flag_q,
  output logic          hit_level
);

  logic [CW-1:0] cnt_nxt;
  logic          flag_nxt;

  always_comb begin
    case ({push_fire, pop_fire})
      2'b10:   cnt_nxt = cnt_q + CW'(1);
      2'b01:   cnt_nxt = cnt_q - CW'(1);
      default: cnt_nxt = cnt_q;
    endcase
    if (clr) cnt_nxt = '0;
  end

  assign hit_level = (cnt_nxt >= lvl);

  always_comb begin
    flag_nxt = rxf_pkg::flag_update(flag_q, push_fire, pop_fire, hit_level);
    if (clr) flag_nxt = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_nxt;
      flag_q <= flag_nxt;
    end
  end

  AST_COUNT_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH)); // R3

  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0 && !flag_q)); // R8

  AST_PAIR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (push_fire && pop_fire && !clr) |=> $stable(cnt_q)); // R7

  AST_FLAG_ON_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
    (push_fire && !pop_fire && !clr && hit_level) |=> flag_q); // R4

  AST_FLAG_OFF_POP: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_fire && !push_fire && !clr && !hit_level) |=> !flag_q); // R5

endmodule

// File: rtl/rxf_irq.sv
module rxf_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic set_evt,
  input  logic irq_en,
  output logic irq
);

  logic irq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       irq_q <= 1'b0;
    else if (!irq_en) irq_q <= 1'b0;
    else if (set_evt) irq_q <= 1'b1;
  end

  assign irq = irq_q & irq_en;

  AST_IRQ_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
    (set_evt && irq_en) |=> irq_q); // R9

  AST_IRQ_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_en && !set_evt) |=> !irq_q); // R9

endmodule

// File: rtl/rx_trig_fifo.sv
module rx_trig_fifo #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned W     = 8,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_valid,
  input  logic [W-1:0]  rx_data,
  input  logic          rd_pop,
  input  logic          fifo_clear,
  input  logic [1:0]    trig_sel,
  input  logic          rx_en,
  input  logic          rx_irq_en,
  output logic [W-1:0]  rd_data,
  output logic [CW-1:0] fill_count,
  output logic          rx_ready,
  output logic          data_full,
  output logic          rx_irq
);

  logic          push_fire, pop_fire, hit_level, empty;
  logic [CW-1:0] lvl;
  int unsigned   lvl_raw;

  // Clamp the decoded level to the depth for small instances.
  always_comb begin
    lvl_raw = rxf_pkg::trig_level(trig_sel);
    lvl     = (lvl_raw > DEPTH) ? CW'(DEPTH) : CW'(lvl_raw);
  end

  assign empty     = (fill_count == '0);
  assign rx_ready  = rx_en && (fill_count < CW'(DEPTH));
  assign push_fire = rx_valid && rx_ready && !fifo_clear;
  assign pop_fire  = rd_pop && !empty && !fifo_clear;

  rxf_store #(.DEPTH(DEPTH), .W(W)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr      (push_fire),
    .wr_data (rx_data),
    .rd      (pop_fire),
    .clr     (fifo_clear),
    .empty   (empty),
    .rd_data (rd_data)
  );

  rxf_level #(.DEPTH(DEPTH)) u_level (
    .clk       (clk),
    .rst_n     (rst_n),
    .push_fire (push_fire),
    .pop_fire  (pop_fire),
    .clr       (fifo_clear),
    .lvl       (lvl),
    .cnt_q     (fill_count),
    .flag_q    (data_full),
    .hit_level (hit_level)
  );

  rxf_irq u_irq (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_evt (push_fire && hit_level),
    .irq_en  (rx_irq_en),
    .irq     (rx_irq)
  );

  AST_FULL_REFUSES: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_count == CW'(DEPTH)) |-> !rx_ready); // R3

  AST_OFF_REFUSES: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |-> !rx_ready); // R11

  AST_EMPTY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_count == '0) |-> (rd_data == '0)); // R6

  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_irq_en |-> !rx_irq); // R9

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_valid && !rd_pop && !fifo_clear) |=> $stable(fill_count)); // R6

endmodule

// File: tb/rx_trig_fifo_test.sv
module rx_trig_fifo_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_valid = 1'b0;
  logic [7:0] rx_data = 8'h00;
  logic       rd_pop = 1'b0;
  logic       fifo_clear = 1'b0;
  logic [1:0] trig_sel = 2'b00;
  logic       rx_en = 1'b1;
  logic       rx_irq_en = 1'b0;
  logic [7:0] rd_data;
  logic [4:0] fill_count;
  logic       rx_ready, data_full, rx_irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;
  logic [7:0] mdl[$];

  always #5 clk = ~clk;

  rx_trig_fifo uut (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
    .rd_pop(rd_pop), .fifo_clear(fifo_clear), .trig_sel(trig_sel),
    .rx_en(rx_en), .rx_irq_en(rx_irq_en), .rd_data(rd_data),
    .fill_count(fill_count), .rx_ready(rx_ready), .data_full(data_full),
    .rx_irq(rx_irq)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] b);
    @(negedge clk);
    rx_valid = 1'b1; rx_data = b;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic pop();
    @(negedge clk);
    rd_pop = 1'b1;
    @(negedge clk);
    rd_pop = 1'b0;
  endtask

  task automatic clear();
    @(negedge clk);
    fifo_clear = 1'b1;
    @(negedge clk);
    fifo_clear = 1'b0;
  endtask

  task automatic t_reset();
    check("R10 count", fill_count, 0);
    check("R10 data_full", data_full, 0);
    check("R10 rx_irq", rx_irq, 0);
    check("R10 rx_ready", rx_ready, 1);
  endtask

  task automatic t_order_wrap();
    clear();
    trig_sel = 2'b00;
    for (int i = 0; i < 10; i++) push(8'(i));
    for (int i = 0; i < 10; i++) pop();
    mdl.delete();
    for (int i = 0; i < 16; i++) begin
      push(8'h40 + 8'(i));
      mdl.push_back(8'h40 + 8'(i));
    end
    check("R3 count at full", fill_count, 16);
    check("R3 rx_ready at full", rx_ready, 0);
    check("R4 flag at full", data_full, 1);
    push(8'hEE);
    check("R3 dropped byte count", fill_count, 16);
    for (int i = 0; i < 16; i++) begin
      check("R1 order across wrap", rd_data, mdl.pop_front());
      pop();
    end
    check("R5 flag after drain", data_full, 0);
    check("R6 empty after drain", fill_count, 0);
  endtask

  task automatic t_levels();
    int lv;
    for (int s = 0; s < 4; s++) begin
      clear();
      trig_sel = 2'(s);
      lv = (s == 0) ? 1 : (s == 1) ? 4 : (s == 2) ? 8 : 14;
      for (int n = 1; n <= 15; n++) begin
        push(8'(n));
        check($sformatf("R2 R4 sel%0d n%0d flag", s, n), data_full, (n >= lv) ? 1 : 0);
      end
    end
  endtask

  task automatic t_pop_level();
    clear();
    trig_sel = 2'b10;
    for (int i = 0; i < 9; i++) push(8'h10 + 8'(i));
    check("R4 flag at 9 of 8", data_full, 1);
    pop();
    check("R5 flag kept at 8", data_full, 1);
    check("R5 count 8", fill_count, 8);
    check("R5 rd_data next", rd_data, 8'h11);
    pop();
    check("R5 flag cleared at 7", data_full, 0);
  endtask

  task automatic t_empty_read();
    clear();
    check("R6 rd_data zero", rd_data, 0);
    pop();
    check("R6 count stays 0", fill_count, 0);
    check("R6 flag stays 0", data_full, 0);
    push(8'h5A);
    check("R6 later push readable", rd_data, 8'h5A);
  endtask

  task automatic t_pair();
    clear();
    trig_sel = 2'b01;
    push(8'hA1); push(8'hA2); push(8'hA3);
    @(negedge clk);
    check("R7 oldest during pair", rd_data, 8'hA1);
    rx_valid = 1'b1; rx_data = 8'hA4; rd_pop = 1'b1;
    @(negedge clk);
    rx_valid = 1'b0; rd_pop = 1'b0;
    check("R7 count unchanged", fill_count, 3);
    check("R7 flag below level", data_full, 0);
    check("R7 next byte", rd_data, 8'hA2);
    pop(); pop();
    check("R7 pushed byte last", rd_data, 8'hA4);
  endtask

  task automatic t_clear_prio();
    clear();
    trig_sel = 2'b00;
    for (int i = 0; i < 5; i++) push(8'h70 + 8'(i));
    @(negedge clk);
    fifo_clear = 1'b1; rx_valid = 1'b1; rx_data = 8'hCC; rd_pop = 1'b1;
    @(negedge clk);
    fifo_clear = 1'b0; rx_valid = 1'b0; rd_pop = 1'b0;
    check("R8 count cleared", fill_count, 0);
    check("R8 flag cleared", data_full, 0);
    check("R8 rd_data zero", rd_data, 0);
  endtask

  task automatic t_irq();
    clear();
    trig_sel = 2'b01;
    rx_irq_en = 1'b1;
    push(1); push(2); push(3);
    check("R9 no irq below level", rx_irq, 0);
    push(4);
    check("R9 irq at level", rx_irq, 1);
    @(negedge clk);
    rx_irq_en = 1'b0;
    #1;
    check("R9 masked at once", rx_irq, 0);
    @(negedge clk);
    rx_irq_en = 1'b1;
    #1;
    check("R9 not restored", rx_irq, 0);
    push(5);
    check("R9 raised again", rx_irq, 1);
    rx_irq_en = 1'b0;
  endtask

  task automatic t_disabled();
    clear();
    rx_en = 1'b0;
    #1;
    check("R11 ready low", rx_ready, 0);
    push(8'h33);
    check("R11 byte ignored", fill_count, 0);
    rx_en = 1'b1;
    #1;
    check("R11 ready back", rx_ready, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_order_wrap();
    t_levels();
    t_pop_level();
    t_empty_read();
    t_pair();
    t_clear_prio();
    t_irq();
    t_disabled();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule